// File: doc/BRIEF.md
# Effective Address Generator with Page-Cross Detection

This unit resolves the effective address of one instruction for an 8-bit processor with a 16-bit address space. A request carries an addressing-mode code, the address where the instruction's operand bytes begin, the two index registers and the address of the following instruction. The unit fetches as many operand and pointer bytes as the mode needs through a single byte-wide memory read port. It then returns a 16-bit effective address, a flag that tells the execute stage to act on the accumulator, and a flag that reports a carry across a 256-byte page during indexing.

The request side is a valid/ready stream. `req_ready` is high only while the unit is idle, and a request is taken on the clock edge where both `req_valid` and `req_ready` are high. The memory port is two valid/ready channels with one read outstanding at a time. While `mem_req_valid` is high and `mem_req_ready` is low, the unit holds the request and its address. `mem_rsp_ready` is high only while the unit waits for the byte it asked for, so a response offered at any other time is neither taken nor used. When the result is ready, `done` pulses for one cycle, and `ea`, `acc_sel` and `page_cross` keep their values until the next request completes.

Mode codes: 0 immediate, 1 accumulator, 2 zero page, 3 zero page indexed by X, 4 zero page indexed by Y, 5 absolute, 6 absolute indexed by X, 7 absolute indexed by Y, 8 indirect, 9 indexed-indirect by X, 10 indirect-indexed by Y, 11 relative. Codes 12 to 15 are unused.

Top module: `eaddr_gen`

## Requirements
- R1: After reset `done`, `mem_req_valid`, `acc_sel` and `page_cross` are 0, `ea` is 0 and `req_ready` is 1.
- R2: Immediate mode (code 0) makes no memory read and returns `ea` equal to the operand address, with `acc_sel` 0 and `page_cross` 0.
- R3: Accumulator mode (code 1) makes no memory read and returns `acc_sel` 1, `page_cross` 0 and `ea` equal to the operand address. Every other mode returns `acc_sel` 0.
- R4: The zero-page modes (codes 2, 3, 4) read one byte at the operand address. `ea` is {0x00, byte + index mod 256}, where the index is 0 for code 2, X for code 3 and Y for code 4. `page_cross` is 0.
- R5: Absolute mode (code 5) reads the operand address and then the operand address + 1, with a 16-bit increment that wraps 0xFFFF to 0x0000. `ea` is {second byte, first byte} and `page_cross` is 0.
- R6: The absolute indexed modes (code 6 uses X, code 7 uses Y) read the base as in R5. `ea` is the 16-bit sum of base and index. `page_cross` is the carry out of base[7:0] + index. Only codes 6, 7 and 10 ever return `page_cross` 1.
- R7: Indirect mode (code 8) reads the pointer P as in R5. It then reads the low byte at P and the high byte at {P[15:8], P[7:0]+1 mod 256}, and returns `ea` = {high, low}.
- R8: Indexed-indirect mode (code 9) reads byte B at the operand address and forms Z = B + X mod 256. It reads the low byte at {0x00, Z} and the high byte at {0x00, Z+1 mod 256}. `ea` is {high, low}.
- R9: Indirect-indexed mode (code 10) reads byte B at the operand address. It reads the low byte at {0x00, B} and the high byte at {0x00, B+1 mod 256} to form a base, then adds Y with the result and `page_cross` of R6.
- R10: Relative mode (code 11) reads one byte at the operand address, sign-extends it to 16 bits and adds it to the next-instruction address, modulo 65536. `page_cross` is 0.
- R11: Reads are issued one at a time in the order listed above. While `mem_req_ready` is low, `mem_req_valid` stays high with `mem_addr` unchanged. Stalls on either memory channel change no result.
- R12: `done` is high for exactly one cycle per request. `req_ready` is low from the cycle after acceptance until `done`. `ea`, `acc_sel` and `page_cross` do not change after `done` until the next request completes.
- R13: Unused mode codes 12 to 15 behave as immediate mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_mode | input | 4 | Addressing-mode code |
| req_opr | input | 16 | Address of the first operand byte |
| req_x | input | 8 | X index register |
| req_y | input | 8 | Y index register |
| req_next_pc | input | 16 | Address of the following instruction |
| mem_req_valid | output | 1 | Byte read requested |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_addr | output | 16 | Byte read address |
| mem_rsp_valid | input | 1 | Read data offered |
| mem_rsp_ready | output | 1 | Unit waits for read data |
| mem_rsp_data | input | 8 | Read data byte |
| done | output | 1 | One-cycle strobe, result valid |
| ea | output | 16 | Effective address |
| acc_sel | output | 1 | Operation targets the accumulator |
| page_cross | output | 1 | Indexing carried out of the low byte |

## Verification
The assertions assume that memory returns exactly one response per accepted read, never before that read, with valid data whenever `mem_rsp_valid` is high. The page checks also assume that the mode code is one of the listed values while a request is in flight. The bench's memory model enforces this by keeping one read pending and answering only after accepting a request. It adds stalls on both channels in some runs, and it drives requests only while the previous one is finished and the unit is idle.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int MODE_W = 4;
  localparam int MAX_RD = 4;
  localparam int STEP_W = $clog2(MAX_RD);
  localparam int NEED_W = $clog2(MAX_RD + 1);

  typedef enum logic [MODE_W-1:0] {
    AM_IMM = 4'd0,
    AM_ACC = 4'd1,
    AM_ZPG = 4'd2,
    AM_ZPX = 4'd3,
    AM_ZPY = 4'd4,
    AM_ABS = 4'd5,
    AM_ABX = 4'd6,
    AM_ABY = 4'd7,
    AM_IND = 4'd8,
    AM_IZX = 4'd9,
    AM_IZY = 4'd10,
    AM_REL = 4'd11
  } am_e;

  // Number of byte reads a mode needs before its address is known.
  function automatic logic [NEED_W-1:0] reads_needed(input logic [MODE_W-1:0] m);
    case (m)
      AM_ZPG, AM_ZPX, AM_ZPY, AM_REL: reads_needed = NEED_W'(1);
      AM_ABS, AM_ABX, AM_ABY:         reads_needed = NEED_W'(2);
      AM_IZX, AM_IZY:                 reads_needed = NEED_W'(3);
      AM_IND:                         reads_needed = NEED_W'(4);
      default:                        reads_needed = NEED_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/eag_addr.sv
module eag_addr
  import eag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] opr,
  input  logic [BYTE_W-1:0] xi,
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [BYTE_W-1:0] PAGE0 = '0;

  logic [BYTE_W-1:0] zp_ptr;
  logic [BYTE_W-1:0] zp_next;
  logic [BYTE_W-1:0] ptr_next;

  // Pointer location inside page zero; increments wrap within the page.
  always_comb begin
    zp_ptr   = (mode == AM_IZX) ? b0 + xi : b0;
    zp_next  = zp_ptr + BYTE_W'(1);
    ptr_next = b0 + BYTE_W'(1);
  end

  always_comb begin
    case (step)
      2'd0: addr = opr;
      2'd1: begin
        if (mode == AM_IZX || mode == AM_IZY) addr = {PAGE0, zp_ptr};
        else                                  addr = opr + ADDR_W'(1);
      end
      2'd2: begin
        if (mode == AM_IND) addr = {b1, b0};
        else                addr = {PAGE0, zp_next};
      end
      default: addr = {b1, ptr_next};
    endcase
  end
endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] opr,
  input  logic [ADDR_W-1:0] npc,
  input  logic [BYTE_W-1:0] xi,
  input  logic [BYTE_W-1:0] yi,
  input  logic [BYTE_W-1:0] b0,
  input  logic [BYTE_W-1:0] b1,
  input  logic [BYTE_W-1:0] b2,
  input  logic [BYTE_W-1:0] b3,
  output logic [ADDR_W-1:0] ea,
  output logic              acc,
  output logic              pg
);
  localparam logic [BYTE_W-1:0] PAGE0 = '0;

  logic [ADDR_W-1:0] ix_base;
  logic [BYTE_W-1:0] ix;
  logic [BYTE_W:0]   lo_sum;
  logic [ADDR_W-1:0] rel_off;

  always_comb begin
    ix_base = {b1, b0};
    ix      = xi;
    if (mode == AM_ABY) ix = yi;
    if (mode == AM_IZY) begin
      ix_base = {b2, b1};
      ix      = yi;
    end
    lo_sum  = {1'b0, ix_base[BYTE_W-1:0]} + {1'b0, ix};
    rel_off = {{BYTE_W{b0[BYTE_W-1]}}, b0};
  end

  always_comb begin
    ea  = opr;
    acc = 1'b0;
    pg  = 1'b0;
    case (mode)
      AM_ACC: acc = 1'b1;
      AM_ZPG: ea  = {PAGE0, b0};
      AM_ZPX: ea  = {PAGE0, b0 + xi};
      AM_ZPY: ea  = {PAGE0, b0 + yi};
      AM_ABS: ea  = {b1, b0};
      AM_ABX, AM_ABY, AM_IZY: begin
        ea = ix_base + {PAGE0, ix};
        pg = lo_sum[BYTE_W];
      end
      AM_IND: ea  = {b3, b2};
      AM_IZX: ea  = {b2, b1};
      AM_REL: ea  = npc + rel_off;
      default: ea = opr;
    endcase
  end
endmodule

// File: rtl/eaddr_gen.sv
module eaddr_gen
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [ADDR_W-1:0] req_opr,
  input  logic [BYTE_W-1:0] req_x,
  input  logic [BYTE_W-1:0] req_y,
  input  logic [ADDR_W-1:0] req_next_pc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [BYTE_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic              acc_sel,
  output logic              page_cross
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_FIN} st_e;

  st_e               st;
  logic [MODE_W-1:0] mode_q;
  logic [ADDR_W-1:0] opr_q;
  logic [ADDR_W-1:0] npc_q;
  logic [BYTE_W-1:0] x_q;
  logic [BYTE_W-1:0] y_q;
  logic [STEP_W-1:0] step_q;
  logic [NEED_W-1:0] need_q;
  logic [BYTE_W-1:0] byte_w [MAX_RD];
  logic [NEED_W-1:0] start_need;
  logic              last_step;
  logic [ADDR_W-1:0] calc_ea;
  logic              calc_acc;
  logic              calc_pg;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_rsp_ready = (st == S_RSP);
  assign start_need    = reads_needed(req_mode);
  assign last_step     = ({1'b0, step_q} == need_q - NEED_W'(1));

  // One capture register per fetched byte, loaded on its own step.
  for (genvar g = 0; g < MAX_RD; g++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (st == S_RSP && mem_rsp_valid && step_q == STEP_W'(g))
        q <= mem_rsp_data;
    end
    assign byte_w[g] = q;
  end

  eag_addr u_addr (
    .mode (mode_q),
    .step (step_q),
    .opr  (opr_q),
    .xi   (x_q),
    .b0   (byte_w[0]),
    .b1   (byte_w[1]),
    .addr (mem_addr)
  );

  eag_calc u_calc (
    .mode (mode_q),
    .opr  (opr_q),
    .npc  (npc_q),
    .xi   (x_q),
    .yi   (y_q),
    .b0   (byte_w[0]),
    .b1   (byte_w[1]),
    .b2   (byte_w[2]),
    .b3   (byte_w[3]),
    .ea   (calc_ea),
    .acc  (calc_acc),
    .pg   (calc_pg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mode_q     <= '0;
      opr_q      <= '0;
      npc_q      <= '0;
      x_q        <= '0;
      y_q        <= '0;
      step_q     <= '0;
      need_q     <= '0;
      done       <= 1'b0;
      ea         <= '0;
      acc_sel    <= 1'b0;
      page_cross <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            mode_q <= req_mode;
            opr_q  <= req_opr;
            npc_q  <= req_next_pc;
            x_q    <= req_x;
            y_q    <= req_y;
            step_q <= '0;
            need_q <= start_need;
            st     <= (start_need == '0) ? S_FIN : S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_RSP;
        S_RSP: begin
          if (mem_rsp_valid) begin
            if (last_step) begin
              st <= S_FIN;
            end else begin
              step_q <= step_q + STEP_W'(1);
              st     <= S_REQ;
            end
          end
        end
        default: begin
          ea         <= calc_ea;
          acc_sel    <= calc_acc;
          page_cross <= calc_pg;
          done       <= 1'b1;
          st         <= S_IDLE;
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R12

  AST_ZP_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done && (mode_q == AM_ZPG || mode_q == AM_ZPX || mode_q == AM_ZPY)
    |-> ea[ADDR_W-1:BYTE_W] == '0); // R4

  AST_PAGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    done && page_cross |-> (mode_q == AM_ABX || mode_q == AM_ABY || mode_q == AM_IZY)); // R6

  AST_ACC_ONLY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> acc_sel == (mode_q == AM_ACC)); // R3

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$past(done) && $past(rst_n) && !(st == S_IDLE) |-> $stable(ea)); // R12
endmodule

// File: tb/eaddr_gen_test.sv
module eaddr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [15:0] req_opr = '0;
  logic [7:0]  req_x = '0;
  logic [7:0]  req_y = '0;
  logic [15:0] req_next_pc = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [7:0]  mem_rsp_data = '0;
  logic        done;
  logic [15:0] ea;
  logic        acc_sel;
  logic        page_cross;

  always #2 clk = ~clk;

  eaddr_gen uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_opr(req_opr), .req_x(req_x), .req_y(req_y), .req_next_pc(req_next_pc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .done(done), .ea(ea), .acc_sel(acc_sel), .page_cross(page_cross)
  );

  typedef struct packed {
    logic [15:0] ea;
    logic        acc;
    logic        pg;
    logic [2:0]  n;
    logic [63:0] addrs;
  } exp_t;

  logic [7:0]  mem [65536];
  exp_t        exp_q [$];
  string       tag_q [$];
  logic [15:0] alog [$];
  int          checks = 0;
  int          errors = 0;
  int          done_cnt = 0;
  bit          stall_en = 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Reference model written from the requirements.
  function automatic exp_t model(input logic [3:0] m, input logic [15:0] o,
                                 input logic [7:0] xx, input logic [7:0] yy, input logic [15:0] pc);
    exp_t e;
    logic [7:0] b0, b1, b2, b3, z, idx;
    logic [15:0] o1, p, base;
    logic [8:0] s;
    e = '0;
    e.ea = o;
    o1 = o + 16'd1;
    case (m)
      4'd1: e.acc = 1'b1;
      4'd2, 4'd3, 4'd4: begin
        b0 = mem[o];
        idx = (m == 4'd2) ? 8'h00 : (m == 4'd3) ? xx : yy;
        z = b0 + idx;
        e.n = 3'd1; e.addrs[15:0] = o;
        e.ea = {8'h00, z};
      end
      4'd5, 4'd6, 4'd7: begin
        b0 = mem[o]; b1 = mem[o1];
        base = {b1, b0};
        idx = (m == 4'd5) ? 8'h00 : (m == 4'd6) ? xx : yy;
        s = {1'b0, b0} + {1'b0, idx};
        e.n = 3'd2; e.addrs[15:0] = o; e.addrs[31:16] = o1;
        e.ea = base + {8'h00, idx};
        e.pg = (m == 4'd5) ? 1'b0 : s[8];
      end
      4'd8: begin
        b0 = mem[o]; b1 = mem[o1];
        p = {b1, b0};
        b2 = mem[p];
        b3 = mem[{p[15:8], p[7:0] + 8'd1}];
        e.n = 3'd4;
        e.addrs = {p[15:8], p[7:0] + 8'd1, p, o1, o};
        e.ea = {b3, b2};
      end
      4'd9, 4'd10: begin
        b0 = mem[o];
        z = (m == 4'd9) ? b0 + xx : b0;
        b1 = mem[{8'h00, z}];
        b2 = mem[{8'h00, z + 8'd1}];
        e.n = 3'd3;
        e.addrs[15:0] = o; e.addrs[31:16] = {8'h00, z}; e.addrs[47:32] = {8'h00, z + 8'd1};
        if (m == 4'd9) e.ea = {b2, b1};
        else begin
          s = {1'b0, b1} + {1'b0, yy};
          e.ea = {b2, b1} + {8'h00, yy};
          e.pg = s[8];
        end
      end
      4'd11: begin
        b0 = mem[o];
        e.n = 3'd1; e.addrs[15:0] = o;
        e.ea = pc + {{8{b0[7]}}, b0};
      end
      default: e.ea = o;
    endcase
    return e;
  endfunction

  // Memory responder: one pending read, optional stalls on both channels.
  initial begin
    bit hreq, hrsp, pend;
    logic [15:0] a, paddr;
    int tick;
    pend = 1'b0; tick = 0; paddr = '0;
    forever begin
      @(negedge clk);
      hreq = mem_req_valid && mem_req_ready;
      hrsp = mem_rsp_valid && mem_rsp_ready;
      a = mem_addr;
      @(posedge clk);
      #1;
      if (hrsp) mem_rsp_valid = 1'b0;
      if (hreq) begin pend = 1'b1; paddr = a; alog.push_back(a); end
      tick++;
      if (pend && !mem_rsp_valid && !(stall_en && (tick % 3 != 0))) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[paddr];
        pend = 1'b0;
      end
      mem_req_ready = !(stall_en && (tick % 4 != 1));
    end
  end

  // Monitor: pops the expected item on every done strobe.
  initial begin
    exp_t e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12 unexpected done actual=1 expected=0");
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, "ea", 32'(ea), 32'(e.ea));
          check(t, "acc_sel", 32'(acc_sel), 32'(e.acc));
          check(t, "page_cross", 32'(page_cross), 32'(e.pg));
          check(t, "read count", 32'(alog.size()), 32'(e.n));
          for (int k = 0; k < alog.size() && k < int'(e.n); k++)
            check(t, "read address", 32'(alog[k]), 32'(e.addrs[16*k +: 16]));
        end
        alog.delete();
        done_cnt++;
      end
    end
  end

  task automatic run(input logic [3:0] m, input logic [15:0] o, input logic [7:0] xx,
                     input logic [7:0] yy, input logic [15:0] pc, input string tag);
    exp_t e;
    int c;
    e = model(m, o, xx, yy, pc);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    c = done_cnt;
    @(negedge clk);
    req_mode = m; req_opr = o; req_x = xx; req_y = yy; req_next_pc = pc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12", "req_ready while busy", 32'(req_ready), 32'd0);
    wait (done_cnt == c + 1);
    @(negedge clk);
    check("R12", "done after strobe", 32'(done), 32'd0);
    check("R12", "ea held", 32'(ea), 32'(e.ea));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + (i >> 8) * 13);
    mem[16'h0300] = 8'h44; mem[16'h0301] = 8'hF0; mem[16'h0302] = 8'h7F;
    mem[16'hFFFF] = 8'hCD; mem[16'h0000] = 8'hAB;
    mem[16'h0400] = 8'hF0; mem[16'h0401] = 8'h20;
    mem[16'h0410] = 8'hFF; mem[16'h0411] = 8'h12;
    mem[16'h12FF] = 8'h34; mem[16'h1200] = 8'h56; mem[16'h1300] = 8'h99;
    mem[16'h0420] = 8'hFE; mem[16'h00FF] = 8'h78; mem[16'h0100] = 8'h11;
    mem[16'h0430] = 8'hFF;
    mem[16'h0440] = 8'h80; mem[16'h0441] = 8'h7F;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "done", 32'(done), 32'd0);
    check("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);
    check("R1", "req_ready", 32'(req_ready), 32'd1);
    check("R1", "ea", 32'(ea), 32'd0);
    check("R1", "flags", 32'({acc_sel, page_cross}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(4'd0,  16'h1234, 8'h11, 8'h22, 16'h1236, "R2");  // R2 immediate
    run(4'd1,  16'h2345, 8'h00, 8'h00, 16'h2346, "R3");  // R3 accumulator
    run(4'd2,  16'h0300, 8'h55, 8'h66, 16'h0302, "R4");  // R4 zero page
    run(4'd3,  16'h0301, 8'h20, 8'h00, 16'h0303, "R4");  // R4 X wraps in page zero
    run(4'd4,  16'h0302, 8'h00, 8'h81, 16'h0304, "R4");  // R4 Y wraps to 0x0000
    run(4'd5,  16'hFFFF, 8'h00, 8'h00, 16'h0002, "R5");  // R5 operand address wrap
    run(4'd6,  16'h0400, 8'h20, 8'h00, 16'h0403, "R6");  // R6 page crossed
    run(4'd7,  16'h0400, 8'h00, 8'h0F, 16'h0403, "R6");  // R6 no crossing
    run(4'd8,  16'h0410, 8'h00, 8'h00, 16'h0413, "R7");  // R7 in-page pointer wrap
    run(4'd9,  16'h0420, 8'h01, 8'h00, 16'h0422, "R8");  // R8 zero page pointer wrap
    run(4'd10, 16'h0430, 8'h00, 8'h90, 16'h0432, "R9");  // R9 wrap plus page cross
    run(4'd10, 16'h0430, 8'h00, 8'h05, 16'h0432, "R9");  // R9 no crossing
    run(4'd11, 16'h0440, 8'h00, 8'h00, 16'h1000, "R10"); // R10 backward
    run(4'd11, 16'h0441, 8'h00, 8'h00, 16'h10F0, "R10"); // R10 forward
    run(4'd13, 16'h0BEE, 8'h12, 8'h34, 16'h0BF0, "R13"); // R13 unused code
    run(4'd15, 16'h4321, 8'hFF, 8'hFF, 16'h4323, "R13"); // R13 unused code
    stall_en = 1'b1;
    run(4'd8,  16'h0410, 8'h00, 8'h00, 16'h0413, "R11"); // R11 stalls
    run(4'd10, 16'h0430, 8'h00, 8'h90, 16'h0432, "R11"); // R11 stalls
    run(4'd6,  16'h0400, 8'h20, 8'h00, 16'h0403, "R11"); // R11 stalls
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R12", "no extra result", 32'(exp_q.size()), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule